// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Divider

This block divides one unsigned integer by another over several clock cycles and produces a quotient and a remainder. A caller presents a dividend and a divisor together with a one-cycle start pulse. The divider then computes one quotient bit per clock. A partial remainder register one bit wider than the operands holds a sign that steers each step. When that sign is clear the step subtracts the divisor, and when it is set the step adds the divisor back. Each step therefore makes exactly one pass through a single shared adder.

After the last quotient bit has been formed, one correction cycle adds the divisor once more if the partial remainder is still negative. Then `done` pulses for one cycle. The quotient and remainder stay on the outputs until the next division is accepted. A zero divisor bypasses the loop and returns a defined result at once. The operand width is the parameter `W`, which must be at least 2.

Top module: `seq_nrdiv`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: A nonzero division is accepted when `start` is sampled high while `busy` is 0. `busy` is then high for exactly W+1 cycles (W quotient steps and one correction). `done` is high for one cycle directly after that, which is W+1 cycles after the accepting edge.
- R3: When `done` is high after a nonzero divisor D and a dividend N, `quotient*D + remainder == N` and `remainder < D`.
- R4: When `start` is not accepted, `quotient` and `remainder` keep their values, including in the cycles after `done`, whatever the operand inputs do.
- R5: `start` is ignored while `busy` is high. The running division completes with its original operands and its original timing.
- R6: A zero divisor makes `done` high in the cycle right after the accepting edge, with no busy cycles. `quotient` is then all ones and `remainder` equals the dividend.
- R7: `busy` and `done` are never high in the same cycle.
- R8: The boundary cases produce the exact results: a dividend smaller than the divisor gives quotient 0 and the dividend as remainder, divide-by-one returns the dividend, equal operands give 1 remainder 0, a zero dividend gives 0 remainder 0, and 8 divided by 3 gives 2 remainder 2.
- R9: A new `start` in the same cycle that `done` is high is accepted, so divisions can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; sampled only when not busy |
| dividend | input | W | Unsigned dividend, captured on an accepted start |
| divisor | input | W | Unsigned divisor, captured on an accepted start |
| busy | output | 1 | Division in progress (steps or correction) |
| done | output | 1 | One-cycle pulse when the results are valid |
| quotient | output | W | Quotient, held until the next accepted start |
| remainder | output | W | Remainder, held until the next accepted start |

## Verification
The bound checker keeps its own copy of the operands from each accepted start and counts busy cycles. On every cycle it checks the division identity and the bound on the remainder, the zero-divisor result, the exact latency, that `busy` and `done` never overlap, that the divisor register holds still through a run, and that the internal sign is clear at completion. The bench scenarios cover what a property cannot: a start pulse with different operands injected in the middle of a run, back-to-back starts in the `done` cycle, outputs holding through idle cycles while the operand inputs change, and a pseudo-random sweep of operand pairs checked against independently computed quotients.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } nrd_state_e;

    // Per-cycle datapath controls produced by the sequencer
    typedef struct packed {
        logic load;   // accepted start, nonzero divisor
        logic zero;   // accepted start, zero divisor
        logic step;   // one shift plus add-or-subtract iteration
        logic fix;    // final remainder correction
    } nrd_ctl_t;

    function automatic logic can_accept(nrd_state_e st);
        return (st == ST_IDLE) || (st == ST_DONE);
    endfunction

endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
    parameter int N = 9
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sub,
    output logic [N-1:0] y
);
    logic [N:0]   c;
    logic [N-1:0] bx;

    assign c[0] = sub;
    assign bx   = b ^ {N{sub}};

    // Explicit ripple chain: subtraction adds the ones' complement plus carry-in
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign y[i]   = a[i] ^ bx[i] ^ c[i];
        assign c[i+1] = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
    end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     div_zero,
    output nrd_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    nrd_state_e    state;
    logic [CW-1:0] cnt;
    logic          accept;

    assign accept = start && can_accept(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        state <= div_zero ? ST_DONE : ST_RUN;
                        cnt   <= '0;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIX;
                end
                ST_FIX:  state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load = accept && !div_zero;
        ctl.zero = accept && div_zero;
        ctl.step = (state == ST_RUN);
        ctl.fix  = (state == ST_FIX);
    end

    assign busy = (state == ST_RUN) || (state == ST_FIX);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/seq_nrdiv.sv
module seq_nrdiv
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int AW = W + 1;   // extra sign bit on the partial remainder

    nrd_ctl_t      ctl;
    logic [AW-1:0] a_q;
    logic [W-1:0]  q_q;
    logic [W-1:0]  m_q;
    logic [AW-1:0] a_shift;
    logic [AW-1:0] op_a;
    logic [AW-1:0] sum;
    logic          op_sub;

    nrdiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .div_zero (divisor == '0),
        .ctl      (ctl),
        .busy     (busy),
        .done     (done)
    );

    // Shift A:Q left one place; Q's top bit moves into A
    assign a_shift = {a_q[W-1:0], q_q[W-1]};
    assign op_a    = ctl.fix ? a_q : a_shift;
    // Non-negative A subtracts, negative A adds; the correction always adds
    assign op_sub  = ctl.step && !a_q[W];

    nrdiv_addsub #(.N(AW)) u_addsub (
        .a   (op_a),
        .b   ({1'b0, m_q}),
        .sub (op_sub),
        .y   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            q_q <= '0;
            m_q <= '0;
        end else if (ctl.load) begin
            a_q <= '0;
            q_q <= dividend;
            m_q <= divisor;
        end else if (ctl.zero) begin
            a_q <= {1'b0, dividend};
            q_q <= '1;
            m_q <= divisor;
        end else if (ctl.step) begin
            a_q <= sum;
            q_q <= {q_q[W-2:0], ~sum[W]};
        end else if (ctl.fix && a_q[W]) begin
            a_q <= sum;
        end
    end

    assign quotient  = q_q;
    assign remainder = a_q[W-1:0];
endmodule

// File: rtl/seq_nrdiv_chk.sv
module seq_nrdiv_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         a_sign,
    input logic [W-1:0] m_val
);
    localparam int CW = $clog2(W + 3) + 1;

    logic [W-1:0]  sh_dd;
    logic [W-1:0]  sh_dv;
    logic          sh_ok;
    logic [CW-1:0] busy_cnt;
    logic [2*W:0]  recon;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_dd    <= '0;
            sh_dv    <= '0;
            sh_ok    <= 1'b0;
            busy_cnt <= '0;
        end else if (start && !busy) begin
            sh_dd    <= dividend;
            sh_dv    <= divisor;
            sh_ok    <= 1'b1;
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assign recon = (2*W+1)'(quotient) * (2*W+1)'(sh_dv) + (2*W+1)'(remainder);

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (done && sh_ok && sh_dv != '0) |-> (busy_cnt == CW'(W + 1)));

    a_r3_identity: assert property (@(posedge clk) disable iff (rst)
        (done && sh_ok && sh_dv != '0) |-> (recon == (2*W+1)'(sh_dd) && remainder < sh_dv));

    a_r3_sign_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> !a_sign);

    a_r6_zero_div: assert property (@(posedge clk) disable iff (rst)
        (done && sh_ok && sh_dv == '0) |-> (quotient == '1 && remainder == sh_dd && busy_cnt == '0));

    a_r5_divisor_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(m_val));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

bind seq_nrdiv seq_nrdiv_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .a_sign    (a_q[W]),
    .m_val     (m_q)
);

// File: tb/test_seq_nrdiv.sv
module test_seq_nrdiv;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] dividend;
    logic [W-1:0] divisor;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seq_nrdiv #(.W(W)) i_seq_nrdiv (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_q(input int dd, input int dv);
        return (dv == 0) ? (1 << W) - 1 : dd / dv;
    endfunction

    function automatic int exp_r(input int dd, input int dv);
        return (dv == 0) ? dd : dd % dv;
    endfunction

    // Pulse start at a falling edge; count falling edges until done is seen
    task automatic run_div(input int dd, input int dv, output int cyc);
        start    = 1'b1;
        dividend = W'(dd);
        divisor  = W'(dv);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic div_check(input string req, input int dd, input int dv);
        int cyc;
        run_div(dd, dv, cyc);
        chk(req, "latency", cyc, (dv == 0) ? 0 : W + 1);
        chk(req, "quotient", int'(quotient), exp_q(dd, dv));
        chk(req, "remainder", int'(remainder), exp_r(dd, dv));
        chk("R7", "busy with done", int'(busy && done), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "quotient after reset", int'(quotient), 0);
        chk("R1", "remainder after reset", int'(remainder), 0);
    endtask

    task automatic t_basic();
        div_check("R3", 200, 7);
        div_check("R3", 255, 16);
        div_check("R3", 129, 128);
        div_check("R3", 77, 254);
        @(negedge clk);
    endtask

    task automatic t_busy_window();
        int n;
        start = 1'b1; dividend = 8'd100; divisor = 8'd9;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 60) begin
            chk("R2", "busy during run", int'(busy), 1);
            @(negedge clk);
            n++;
        end
        chk("R2", "busy cycles", n, W + 1);
        @(negedge clk);
        chk("R2", "done is one cycle", int'(done), 0);
    endtask

    task automatic t_boundary();
        div_check("R8", 8, 3);
        div_check("R8", 5, 200);
        div_check("R8", 255, 1);
        div_check("R8", 173, 173);
        div_check("R8", 0, 5);
        div_check("R8", 255, 255);
        @(negedge clk);
    endtask

    task automatic t_ignore_start();
        int n;
        start = 1'b1; dividend = 8'd250; divisor = 8'd11;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        start = 1'b1; dividend = 8'd9; divisor = 8'd2;
        @(negedge clk); n++;
        start = 1'b0;
        chk("R5", "busy after ignored start", int'(busy), 1);
        while (!done && n < 60) begin @(negedge clk); n++; end
        chk("R5", "latency with ignored start", n, W + 1);
        chk("R5", "quotient unaffected", int'(quotient), 250 / 11);
        chk("R5", "remainder unaffected", int'(remainder), 250 % 11);
        @(negedge clk);
    endtask

    task automatic t_hold();
        div_check("R4", 199, 13);
        for (int i = 0; i < 5; i++) begin
            dividend = W'(i * 37 + 3);
            divisor  = W'(i + 1);
            @(negedge clk);
            chk("R4", "quotient held", int'(quotient), 199 / 13);
            chk("R4", "remainder held", int'(remainder), 199 % 13);
            chk("R4", "done low while idle", int'(done), 0);
        end
    endtask

    task automatic t_zero();
        div_check("R6", 123, 0);
        @(negedge clk);
        div_check("R6", 0, 0);
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        div_check("R9", 240, 15);
        div_check("R9", 241, 3);
        div_check("R9", 66, 0);
        div_check("R9", 99, 10);
        @(negedge clk);
    endtask

    task automatic t_sweep();
        logic [15:0] lf = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            div_check("R3", int'(lf[15:8]), int'(lf[7:0] >> (k % 5)));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_busy_window();
        t_boundary();
        t_ignore_start();
        t_hold();
        t_zero();
        t_back_to_back();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule